// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block is one channel of a DMA controller. It runs a single transfer descriptor that has been loaded in one cycle. The descriptor gives the source and destination addresses and a signed per-element step for each. It also carries a size and modulo field for each side, a per-trigger byte count and signed end-of-major-loop adjustments. Two iteration counts complete it, one current and one starting, together with a control word. Each accepted trigger runs one minor loop. A minor loop is a sequence of elements, and each element is one read beat followed by one write beat on a simple single-beat memory port. After the minor loop the engine updates the addresses and the iteration count. It then reports half-way, completion and channel-link events.

The memory port is a request/ready interface. The engine raises `mem_req` together with the address, direction, byte enables and write data. It holds all of them unchanged until it samples `mem_ready` high on a rising clock edge. Holding `mem_ready` low stalls the engine for as long as needed, and no beat is dropped or repeated. Read data is taken in the cycle the read beat completes. The trigger, enable, clear, descriptor and event pins are plain level or pulse signals.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset `busy`, `done`, `req_en`, `mem_req`, `irq_major`, `irq_half` and `link_valid` are all 0.
- R2: The element size is given by the source attribute bits [10:8] for the read and the destination attribute bits [2:0] for the write, with codes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. The element's bytes travel in the byte lanes given by the low two address bits, and the byte enables of each beat cover exactly those lanes.
- R3: After each element the source address moves by the signed 16-bit `d_soff` and the destination address by the signed 16-bit `d_doff`. A step of zero keeps a fixed address.
- R4: A nonzero modulo exponent M (source attribute bits [15:11], destination attribute bits [7:3]) keeps the address bits at and above M unchanged on every address update, so the low M bits wrap inside a 2^M-byte window.
- R5: When the minor loop that brings the count to zero ends, the signed adjustments `d_slast` and `d_dlast` are added to the addresses, the current count reloads from the starting count, and `done` sets.
- R6: When iteration-count bit 15 is 1, the count is bits [8:0] and bits [9+CHW-1:9] hold a link channel. When bit 15 is 0, the count is bits [14:0]. The starting count is decoded by its own bit 15.
- R7: With count linking on, every minor loop except the one that completes the major loop pulses `link_valid` for one cycle, with `link_chan` set to the channel in the current count.
- R8: When control bit 5 is 1, major-loop completion pulses `link_valid`, with `link_chan` taken from control bits [8+CHW-1:8].
- R9: When control bit 1 is 1, major completion pulses `irq_major`. When control bit 2 is 1, a minor loop whose decremented count equals half the starting count (rounded down) pulses `irq_half`.
- R10: When control bit 3 is 1, major completion clears `req_en` and discards any pending trigger. Triggers that arrive while `req_en` is 0 have no effect.
- R11: When byte-count bit 31 (source) or bit 30 (destination) is 1, the byte count is bits [9:0], and the signed value in bits [29:10] is added to the enabled address after every minor loop except the one that completes the major loop. When both bits are 0, the byte count is bits [BCW-1:0].
- R12: An accepted trigger that arrives while a minor loop runs is held as one pending request, and that minor loop runs as soon as the current one ends.
- R13: `done` is cleared by `done_clr` or by `desc_wr`.
- R14: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_wr | input | 1 | Load all descriptor fields (only when idle) |
| d_saddr | input | AW | Source address |
| d_soff | input | 16 | Signed source step per element |
| d_attr | input | 16 | Source attribute [15:8], destination attribute [7:0] |
| d_nbytes | input | 32 | Byte count, with optional minor-loop offset fields |
| d_slast | input | AW | Signed source adjustment at major end |
| d_daddr | input | AW | Destination address |
| d_doff | input | 16 | Signed destination step per element |
| d_dlast | input | AW | Signed destination adjustment at major end |
| d_citer | input | 16 | Current iteration count |
| d_biter | input | 16 | Starting iteration count |
| d_csr | input | 16 | Control word |
| trig | input | 1 | Trigger one minor loop |
| en_set | input | 1 | Set the request enable |
| en_clr | input | 1 | Clear the request enable |
| done_clr | input | 1 | Clear the done flag |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Beat accepted |
| busy | output | 1 | Minor loop running or pending |
| done | output | 1 | Major loop completed |
| req_en | output | 1 | Trigger enable state |
| cur_saddr | output | AW | Current source address |
| cur_daddr | output | AW | Current destination address |
| cur_iter | output | 16 | Current iteration count |
| irq_major | output | 1 | Completion interrupt pulse |
| irq_half | output | 1 | Half-way interrupt pulse |
| link_valid | output | 1 | Channel link request pulse |
| link_chan | output | CHW | Linked channel number |

## Verification
The assertions take three things for granted. The source and destination sizes are equal and valid, every address and step is a multiple of the element size, and `desc_wr` is raised only while `busy` is low. They also assume the byte count is a nonzero multiple of the element size and the starting count is nonzero. The stimulus keeps to these limits by building every descriptor from a size code. Bases are aligned to 32 bytes, and steps, adjustments and loop offsets are whole multiples of the element width. A descriptor is written only after the engine has gone idle. `mem_ready` is stalled at random to exercise the holding rule.

// File: rtl/dde_pkg.sv
package dde_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} dde_state_e;

  localparam int CSR_INT_MAJ  = 1;
  localparam int CSR_INT_HALF = 2;
  localparam int CSR_DREQ     = 3;
  localparam int CSR_MAJ_LINK = 5;
  localparam int CSR_CH_LSB   = 8;
  localparam int IT_ELINK     = 15;
  localparam int IT_CH_LSB    = 9;
  localparam int NB_SMLOE     = 31;
  localparam int NB_DMLOE     = 30;

  function automatic logic [3:0] lane_mask(input logic [2:0] sz);
    case (sz)
      3'd0:    lane_mask = 4'b0001;
      3'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dde_addr_step.sv
module dde_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] inc,
  input  logic [4:0]    modexp,
  output logic [AW-1:0] next
);
  logic [AW-1:0] sum, keep_low;

  always_comb begin
    sum = base + inc;
    if (modexp == 5'd0) keep_low = '1;
    else                keep_low = (AW'(1) << modexp) - AW'(1);
    next = (base & ~keep_low) | (sum & keep_low);
  end
endmodule

// File: rtl/dde_iter.sv
module dde_iter #(
  parameter int CHW = 4
) (
  input  logic [15:0]    citer,
  input  logic [15:0]    biter,
  output logic [15:0]    citer_next,
  output logic           major_done,
  output logic           half_hit,
  output logic           minor_link,
  output logic [CHW-1:0] link_ch
);
  import dde_pkg::*;
  logic [14:0] cnt, bcnt, dec;

  always_comb begin
    cnt  = citer[IT_ELINK] ? {6'd0, citer[8:0]} : citer[14:0];
    bcnt = biter[IT_ELINK] ? {6'd0, biter[8:0]} : biter[14:0];
    dec  = cnt - 15'd1;
    major_done = (dec == 15'd0);
    half_hit   = (dec == (bcnt >> 1));
    minor_link = citer[IT_ELINK] && !major_done;
    link_ch    = citer[IT_CH_LSB +: CHW];
    if (major_done)           citer_next = biter;
    else if (citer[IT_ELINK]) citer_next = {citer[15:9], dec[8:0]};
    else                      citer_next = {1'b0, dec};
  end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int AW  = 32,
  parameter int CHW = 4,
  parameter int BCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           desc_wr,
  input  logic [AW-1:0]  d_saddr,
  input  logic [15:0]    d_soff,
  input  logic [15:0]    d_attr,
  input  logic [31:0]    d_nbytes,
  input  logic [AW-1:0]  d_slast,
  input  logic [AW-1:0]  d_daddr,
  input  logic [15:0]    d_doff,
  input  logic [AW-1:0]  d_dlast,
  input  logic [15:0]    d_citer,
  input  logic [15:0]    d_biter,
  input  logic [15:0]    d_csr,
  input  logic           trig,
  input  logic           en_set,
  input  logic           en_clr,
  input  logic           done_clr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [3:0]     mem_be,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_ready,
  output logic           busy,
  output logic           done,
  output logic           req_en,
  output logic [AW-1:0]  cur_saddr,
  output logic [AW-1:0]  cur_daddr,
  output logic [15:0]    cur_iter,
  output logic           irq_major,
  output logic           irq_half,
  output logic           link_valid,
  output logic [CHW-1:0] link_chan
);
  import dde_pkg::*;
  localparam int MLW = 10;
  localparam int OFW = 20;

  dde_state_e    state;
  logic [AW-1:0] saddr_q, daddr_q, slast_q, dlast_q;
  logic [15:0]   soff_q, doff_q, attr_q, citer_q, biter_q;
  logic [31:0]   nbytes_q, data_q;
  logic          f_imaj, f_ihalf, f_dreq, f_mlink, pend_q, done_q, en_q;
  logic [CHW-1:0] mch_q;
  logic [BCW-1:0] beat_q, bytecnt, beats;

  logic [AW-1:0] mloff;
  logic [15:0]   it_next;
  logic          it_done, it_half, it_mlink, trig_acc;
  logic [CHW-1:0] it_ch;
  logic [AW-1:0] a_base [2];
  logic [AW-1:0] a_inc  [2];
  logic [AW-1:0] a_nxt  [2];
  logic [4:0]    a_mod  [2];
  logic          csr_unused;

  assign csr_unused = ^{d_csr[15:8+CHW], d_csr[7:6], d_csr[4], d_csr[0]};

  dde_iter #(.CHW(CHW)) u_iter (
    .citer(citer_q), .biter(biter_q), .citer_next(it_next),
    .major_done(it_done), .half_hit(it_half), .minor_link(it_mlink), .link_ch(it_ch)
  );

  always_comb begin
    if (nbytes_q[NB_SMLOE] || nbytes_q[NB_DMLOE]) bytecnt = BCW'(nbytes_q[MLW-1:0]);
    else                                          bytecnt = nbytes_q[BCW-1:0];
    beats = bytecnt >> attr_q[10:8];
    mloff = {{(AW-OFW){nbytes_q[29]}}, nbytes_q[29:MLW]};
    a_base[0] = saddr_q;
    a_base[1] = daddr_q;
    a_mod[0]  = attr_q[15:11];
    a_mod[1]  = attr_q[7:3];
    if (state == ST_WR) begin
      a_inc[0] = {{(AW-16){soff_q[15]}}, soff_q};
      a_inc[1] = {{(AW-16){doff_q[15]}}, doff_q};
    end else if (it_done) begin
      a_inc[0] = slast_q;
      a_inc[1] = dlast_q;
    end else begin
      a_inc[0] = nbytes_q[NB_SMLOE] ? mloff : '0;
      a_inc[1] = nbytes_q[NB_DMLOE] ? mloff : '0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_step
    dde_addr_step #(.AW(AW)) u_step (
      .base(a_base[g]), .inc(a_inc[g]), .modexp(a_mod[g]), .next(a_nxt[g])
    );
  end

  assign trig_acc = trig && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      saddr_q <= '0; daddr_q <= '0; slast_q <= '0; dlast_q <= '0;
      soff_q <= '0; doff_q <= '0; attr_q <= '0; citer_q <= '0; biter_q <= '0;
      nbytes_q <= '0; data_q <= '0; beat_q <= '0; mch_q <= '0;
      f_imaj <= 1'b0; f_ihalf <= 1'b0; f_dreq <= 1'b0; f_mlink <= 1'b0;
      pend_q <= 1'b0; done_q <= 1'b0; en_q <= 1'b0;
      irq_major <= 1'b0; irq_half <= 1'b0; link_valid <= 1'b0; link_chan <= '0;
    end else begin
      irq_major  <= 1'b0;
      irq_half   <= 1'b0;
      link_valid <= 1'b0;
      if (en_set) en_q <= 1'b1;
      if (en_clr) en_q <= 1'b0;
      if (done_clr) done_q <= 1'b0;
      if (desc_wr) begin
        saddr_q <= d_saddr; daddr_q <= d_daddr; slast_q <= d_slast; dlast_q <= d_dlast;
        soff_q <= d_soff; doff_q <= d_doff; attr_q <= d_attr; nbytes_q <= d_nbytes;
        citer_q <= d_citer; biter_q <= d_biter;
        f_imaj <= d_csr[CSR_INT_MAJ]; f_ihalf <= d_csr[CSR_INT_HALF];
        f_dreq <= d_csr[CSR_DREQ]; f_mlink <= d_csr[CSR_MAJ_LINK];
        mch_q <= d_csr[CSR_CH_LSB +: CHW];
        done_q <= 1'b0;
        pend_q <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (trig_acc || pend_q) begin
            pend_q <= 1'b0;
            beat_q <= beats;
            state  <= ST_RD;
          end
        end
        ST_RD: begin
          if (trig_acc) pend_q <= 1'b1;
          if (mem_ready) begin
            data_q <= mem_rdata >> {saddr_q[1:0], 3'b000};
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (trig_acc) pend_q <= 1'b1;
          if (mem_ready) begin
            saddr_q <= a_nxt[0];
            daddr_q <= a_nxt[1];
            beat_q  <= beat_q - BCW'(1);
            state   <= (beat_q == BCW'(1)) ? ST_FIN : ST_RD;
          end
        end
        default: begin
          if (trig_acc) pend_q <= 1'b1;
          saddr_q <= a_nxt[0];
          daddr_q <= a_nxt[1];
          citer_q <= it_next;
          irq_half <= f_ihalf && it_half;
          if (it_done) begin
            done_q     <= 1'b1;
            irq_major  <= f_imaj;
            link_valid <= f_mlink;
            link_chan  <= mch_q;
            if (f_dreq) begin
              en_q   <= 1'b0;
              pend_q <= 1'b0;
            end
          end else begin
            link_valid <= it_mlink;
            link_chan  <= it_ch;
          end
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == ST_RD) || (state == ST_WR);
    mem_we    = (state == ST_WR);
    mem_addr  = mem_we ? daddr_q : saddr_q;
    mem_be    = mem_we ? 4'(lane_mask(attr_q[2:0]) << daddr_q[1:0])
                       : 4'(lane_mask(attr_q[10:8]) << saddr_q[1:0]);
    mem_wdata = data_q << {daddr_q[1:0], 3'b000};
    busy      = (state != ST_IDLE) || pend_q;
    done      = done_q;
    req_en    = en_q;
    cur_saddr = saddr_q;
    cur_daddr = daddr_q;
    cur_iter  = citer_q;
  end
endmodule

// File: rtl/dde_checker.sv
module dde_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          busy,
  input logic          done,
  input logic          req_en,
  input logic          dreq_f,
  input logic [15:0]   cur_iter,
  input logic [15:0]   biter_q,
  input logic          irq_major
);
  assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                              && $stable(mem_be) && $stable(mem_wdata));

  assert_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cur_iter == biter_q);

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && dreq_f |-> !req_en);

  assert_irq_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_major |-> done);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind dma_desc_engine dde_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .busy(busy), .done(done),
  .req_en(req_en), .dreq_f(f_dreq), .cur_iter(cur_iter), .biter_q(biter_q),
  .irq_major(irq_major)
);

// File: tb/sim_dma_desc_engine.sv
`timescale 1ns/1ps
module sim_dma_desc_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        desc_wr = 0, trig = 0, en_set = 0, en_clr = 0, done_clr = 0;
  logic [31:0] d_saddr = 0, d_slast = 0, d_daddr = 0, d_dlast = 0, d_nbytes = 0;
  logic [15:0] d_soff = 0, d_doff = 0, d_attr = 0, d_citer = 0, d_biter = 0, d_csr = 0;
  logic        mem_req, mem_we, busy, done, req_en, irq_major, irq_half, link_valid;
  logic [31:0] mem_addr, mem_wdata, cur_saddr, cur_daddr;
  logic [3:0]  mem_be, link_chan;
  logic [15:0] cur_iter;
  logic [31:0] mem_rdata = 0;
  logic        mem_ready = 0;

  dma_desc_engine u0 (.*);

  logic [7:0] mem [256];
  logic [7:0] mm  [256];
  int errs = 0, checks = 0, cyc = 0;
  int n_maj = 0, n_half = 0, n_link = 0;
  logic [3:0] last_ch = 0;
  int e_maj = 0, e_half = 0, e_link = 0;
  logic [3:0] e_ch = 0;
  logic [31:0] m_sa, m_da;
  logic [15:0] m_ci;
  logic m_done = 0, m_en = 0;

  always @(negedge clk) begin
    cyc++;
    mem_ready <= ($urandom % 3) != 0;
    mem_rdata <= {mem[{mem_addr[7:2], 2'd3}], mem[{mem_addr[7:2], 2'd2}],
                  mem[{mem_addr[7:2], 2'd1}], mem[{mem_addr[7:2], 2'd0}]};
    if (irq_major) n_maj++;
    if (irq_half) n_half++;
    if (link_valid) begin n_link++; last_ch = link_chan; end
  end

  always @(posedge clk)
    if (mem_req && mem_we && mem_ready)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[{mem_addr[7:2], 2'(k)}] <= mem_wdata[8*k +: 8];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wrapf(logic [31:0] b, logic [31:0] inc, logic [4:0] m);
    logic [31:0] msk;
    msk = (m == 0) ? 32'hFFFF_FFFF : ((32'd1 << m) - 1);
    return (b & ~msk) | ((b + inc) & msk);
  endfunction

  // reference minor loop, from the requirements
  task automatic model_loop();
    int eb, nb, beats;
    logic [7:0] t [4];
    logic [14:0] cnt, bcnt, dec;
    logic [31:0] adj_s, adj_d, mlo;
    logic el;
    if (!m_en) return;
    eb = 1 << d_attr[10:8];
    nb = (d_nbytes[31] || d_nbytes[30]) ? int'(d_nbytes[9:0]) : int'(d_nbytes[15:0]);
    beats = nb / eb;
    for (int b = 0; b < beats; b++) begin
      for (int k = 0; k < eb; k++) t[k] = mm[8'(m_sa + k)];
      for (int k = 0; k < eb; k++) mm[8'(m_da + k)] = t[k];
      m_sa = wrapf(m_sa, {{16{d_soff[15]}}, d_soff}, d_attr[15:11]);
      m_da = wrapf(m_da, {{16{d_doff[15]}}, d_doff}, d_attr[7:3]);
    end
    el   = m_ci[15];
    cnt  = el ? {6'd0, m_ci[8:0]} : m_ci[14:0];
    bcnt = d_biter[15] ? {6'd0, d_biter[8:0]} : d_biter[14:0];
    dec  = cnt - 1;
    mlo  = {{12{d_nbytes[29]}}, d_nbytes[29:10]};
    if (d_csr[2] && dec == (bcnt >> 1)) e_half++;
    if (dec == 0) begin
      m_done = 1; adj_s = d_slast; adj_d = d_dlast;
      if (d_csr[1]) e_maj++;
      if (d_csr[5]) begin e_link++; e_ch = d_csr[11:8]; end
      if (d_csr[3]) m_en = 0;
      m_ci = d_biter;
    end else begin
      adj_s = d_nbytes[31] ? mlo : 0;
      adj_d = d_nbytes[30] ? mlo : 0;
      if (el) begin e_link++; e_ch = m_ci[12:9]; end
      m_ci = el ? {m_ci[15:9], dec[8:0]} : {1'b0, dec};
    end
    m_sa = wrapf(m_sa, adj_s, d_attr[15:11]);
    m_da = wrapf(m_da, adj_d, d_attr[7:3]);
  endtask

  task automatic load_desc();
    @(negedge clk);
    desc_wr = 1; en_set = 1;
    @(negedge clk);
    desc_wr = 0; en_set = 0;
    m_sa = d_saddr; m_da = d_daddr; m_ci = d_citer; m_done = 0; m_en = 1;
  endtask

  task automatic compare_all(string tag);
    int bad = 0;
    chk({tag, " saddr"}, cur_saddr, m_sa);
    chk({tag, " daddr"}, cur_daddr, m_da);
    chk({tag, " iter"},  {16'd0, cur_iter}, {16'd0, m_ci});
    chk({tag, " done"},  {31'd0, done}, {31'd0, m_done});
    chk({tag, " en"},    {31'd0, req_en}, {31'd0, m_en});
    chk({tag, " irq_major count"}, n_maj, e_maj);
    chk({tag, " irq_half count"},  n_half, e_half);
    chk({tag, " link count"}, n_link, e_link);
    chk({tag, " link chan"}, {28'd0, last_ch}, {28'd0, e_ch});
    for (int i = 0; i < 256; i++) if (mem[i] !== mm[i]) bad++;
    chk({tag, " memory mismatches"}, bad, 0);
  endtask

  // one trigger, or two with the second landing while the first runs
  task automatic fire(string tag, bit twice);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = twice;
    @(negedge clk); trig = 0;
    model_loop();
    if (twice) model_loop();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); mm[i] = mem[i]; end
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 req_en", {31'd0, req_en}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 pulses", {29'd0, irq_major, irq_half, link_valid}, 0);
    rst_n = 1;

    // R2 R3 R5 R9: byte buffer to a fixed register, rewind by -4
    d_saddr = 32'h00; d_soff = 1; d_daddr = 32'h80; d_doff = 0; d_attr = 16'h0000;
    d_nbytes = 1; d_slast = -32'sd4; d_dlast = 0; d_citer = 4; d_biter = 4; d_csr = 16'h0006;
    load_desc();
    for (int i = 0; i < 4; i++) fire("R3 byte buffer", 0);
    chk("R5 source rewound", cur_saddr, 32'h00);
    chk("R9 half pulses", n_half, 1);
    chk("R5 done set", {31'd0, done}, 1);

    // R13 done clear
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0; m_done = 0;
    chk("R13 done_clr", {31'd0, done}, 0);

    // R4 16-bit circular destination, window 8 bytes, 2 elements per trigger
    d_saddr = 32'h10; d_soff = 2; d_daddr = 32'hA0; d_doff = 2; d_attr = 16'h0119;
    d_nbytes = 4; d_slast = -32'sd20; d_citer = 5; d_biter = 5; d_csr = 16'h0002;
    load_desc();
    for (int i = 0; i < 5; i++) fire("R4 circular", 0);
    chk("R4 window kept", {24'd0, cur_daddr[7:3]}, {24'd0, 5'h14});

    // R6 R7 R8 count linking plus major link
    d_saddr = 32'h20; d_soff = 4; d_daddr = 32'hC0; d_doff = 4; d_attr = 16'h0202;
    d_nbytes = 4; d_slast = 0; d_dlast = 0; d_citer = 16'h8000 | (5 << 9) | 3;
    d_biter = d_citer; d_csr = 16'h0920;
    load_desc();
    fire("R7 minor link", 0);
    chk("R7 link chan", {28'd0, link_chan}, 5);
    fire("R6 linked count", 0);
    fire("R8 major link", 0);
    chk("R8 link chan", {28'd0, last_ch}, 9);

    // R11 minor-loop source offset -4 re-reads the same 4 bytes
    d_saddr = 32'h40; d_soff = 1; d_daddr = 32'hD0; d_doff = 1; d_attr = 16'h0000;
    d_nbytes = 32'h8000_0000 | ((32'hFFFF_FFFC & 32'hFFFFF) << 10) | 4;
    d_slast = 0; d_dlast = -32'sd12; d_citer = 3; d_biter = 3; d_csr = 0;
    load_desc();
    fire("R11 offset loop1", 0);
    chk("R11 source back", cur_saddr, 32'h40);
    fire("R11 offset loop2", 0);
    fire("R11 offset loop3", 0);

    // R12 pending trigger
    d_saddr = 32'h60; d_soff = 2; d_daddr = 32'hE0; d_doff = 2; d_attr = 16'h0101;
    d_nbytes = 8; d_slast = 0; d_dlast = 0; d_citer = 6; d_biter = 6; d_csr = 0;
    load_desc();
    fire("R12 pending pair", 1);
    chk("R12 two loops counted", {16'd0, cur_iter}, 4);

    // R10 disable on completion, later trigger ignored
    d_citer = 2; d_biter = 2; d_csr = 16'h0008;
    load_desc();
    fire("R10 first", 1);
    chk("R10 enable cleared", {31'd0, req_en}, 0);
    fire("R10 ignored trigger", 0);
    chk("R10 count unchanged", {16'd0, cur_iter}, 2);

    // R13 descriptor write clears done
    load_desc();
    chk("R13 desc_wr clears done", {31'd0, done}, 0);

    // random descriptors
    for (int n = 0; n < 40; n++) begin
      int s, eb, k;
      s  = $urandom % 3; eb = 1 << s;
      d_saddr = ($urandom % 4) * 32; d_daddr = 128 + ($urandom % 4) * 32;
      k = $urandom % 4; d_soff = (k == 3) ? 16'(-eb) : 16'(k * eb);
      k = $urandom % 4; d_doff = (k == 3) ? 16'(-eb) : 16'(k * eb);
      d_attr = {(($urandom % 2) ? 5'd0 : 5'(3 + $urandom % 3)), 3'(s),
                (($urandom % 2) ? 5'd0 : 5'(3 + $urandom % 3)), 3'(s)};
      d_nbytes = eb * (1 + $urandom % 4);
      if ($urandom % 4 == 0)
        d_nbytes = {1'b1, 1'($urandom % 2), 20'(eb * (int'($urandom % 8) - 4)), 10'(d_nbytes)};
      d_slast = eb * (int'($urandom % 8) - 4); d_dlast = eb * (int'($urandom % 8) - 4);
      k = 1 + $urandom % 6;
      d_citer = ($urandom % 3 == 0) ? 16'(16'h8000 | (($urandom % 16) << 9) | k) : 16'(k);
      d_biter = d_citer;
      d_csr = 16'(($urandom % 8) << 1) & 16'h0006 | (($urandom % 2) << 5) | (($urandom % 16) << 8);
      load_desc();
      for (int t = 0; t < k + 1; t++) fire("R2 random", ($urandom % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule